// File: doc/BRIEF.md
# Serial Port Command and Flow-Control Register

This block holds the command and modem-control state of a serial port. Software changes that state through two addresses. Writing a word to the set address turns on each command bit that is 1 in the word. Writing to the clear address turns off each command bit that is 1 in the word. A bit written as 0 keeps its value. Either address reads back the current command state.

The command bits drive four things:
- the request-to-send line;
- a break condition on the serial output;
- a single-cycle reset strobe for the receive FIFO;
- a single-cycle reset strobe for the transmit FIFO.

The block also applies automatic hardware flow control. It holds a flow-control enable bit and a programmable receive threshold. When flow control is on, request-to-send is withdrawn once the receive FIFO fill reaches the threshold, whatever the command bit says. New transmit frames are also held back while the peer's clear-to-send line is inactive. The bit engine and the FIFO storage lie outside this block; it only gates them.

Top module: `uart_cmd_flowctl`

## Requirements
- R1: A write to address 0x18 sets every command bit that is 1 in `wdata`. Break is bit 3 and request-to-send is bit 5. Command bits written as 0 are unchanged.
- R2: A write to address 0x1C clears every command bit that is 1 in `wdata`. Command bits written as 0 are unchanged.
- R3: A read at 0x18 or 0x1C returns break on bit 3 and request-to-send on bit 5. Every other bit, including the two FIFO reset bits 6 and 7, reads 0.
- R4: A write to 0x18 with bit 6 set raises `rx_fifo_rst` for exactly the one cycle after the write edge. Bit 7 does the same for `tx_fifo_rst`. The same bits written to 0x1C raise no strobe.
- R5: The flow-control enable is written and read at bit 23 of address 0x00. The 5-bit threshold is written and read at bits 20:16 of address 0x14. All other bits at these two addresses read 0.
- R6: `rts_n` is a registered output, updated one clock after its inputs. It is low when the request-to-send command bit is set and either flow control is off or `rx_level` is below the threshold. Otherwise it is high.
- R7: With flow control on and `rx_level` at or above the threshold, `rts_n` is high even though the request-to-send command bit is set.
- R8: `cts_n` passes through a synchroniser of SYNC_STAGES flops, 2 by default. Its synchronised value reads at bit 25 of address 0x04, where 0 means the peer allows transmission.
- R9: `tx_start_ok` is low exactly while flow control is on and the synchronised `cts_n` is 1. A frame already in progress is not cut: `txd` keeps following `tx_ser_in`.
- R10: While the break bit is set, `txd` is 0. Otherwise `txd` equals `tx_ser_in`.
- R11: After reset, the following hold:
  - both command bits are 0 and both strobes are 0;
  - flow control is off and the threshold equals RST_LVL (16 by default);
  - `rts_n` is 1 and `tx_start_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address for writes and reads |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| rx_level | input | RXL_W | Current receive FIFO fill |
| cts_n | input | 1 | Clear-to-send from the peer, active low, asynchronous |
| tx_ser_in | input | 1 | Serial bit from the transmit bit engine |
| rts_n | output | 1 | Request-to-send to the peer, active low |
| tx_start_ok | output | 1 | Permission for the bit engine to begin a new frame |
| txd | output | 1 | Serial output after break forcing |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO reset strobe |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO reset strobe |

## Verification
Results fall due at different times, and the bench drives inputs on the falling edge and checks each result at its own time.
- Command state, its read-back, the break forcing of `txd` and the two strobes are valid right after the write's rising edge. The bench checks them at the falling edge that ends the write.
- `rts_n` carries one more register, so it is checked one falling edge later. A change in `rx_level` reaches `rts_n` after a single edge.
- A change in `cts_n` reaches `tx_start_ok` and the status bit after two edges. The bench checks after one edge that the old value still holds, and checks the new value after the second.

// File: rtl/ucf_pkg.sv
package ucf_pkg;
    // register byte offsets
    localparam int unsigned OFS_CTRL = 32'h00;
    localparam int unsigned OFS_STAT = 32'h04;
    localparam int unsigned OFS_TRIG = 32'h14;
    localparam int unsigned OFS_CSET = 32'h18;
    localparam int unsigned OFS_CCLR = 32'h1C;

    // bit positions
    localparam int unsigned B_BRK    = 3;
    localparam int unsigned B_RTS    = 5;
    localparam int unsigned B_RXRST  = 6;
    localparam int unsigned B_TXRST  = 7;
    localparam int unsigned B_FLOWEN = 23;
    localparam int unsigned B_CTS    = 25;
    localparam int unsigned LVL_LSB  = 16;
endpackage

// File: rtl/ucf_regs.sv
module ucf_regs
    import ucf_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned LVL_W   = 5,
    parameter int unsigned RST_LVL = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              brk,
    output logic              rts_cmd,
    output logic              flow_en,
    output logic [LVL_W-1:0]  lvl,
    output logic              rx_rst,
    output logic              tx_rst
);
    typedef struct packed {
        logic             brk;
        logic             rts;
        logic             flow_en;
        logic [LVL_W-1:0] lvl;
        logic             rx_rst;
        logic             tx_rst;
    } regs_t;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_CSET = ADDR_W'(OFS_CSET);
    localparam logic [ADDR_W-1:0] A_CCLR = ADDR_W'(OFS_CCLR);

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rx_rst = 1'b0;
        r_d.tx_rst = 1'b0;
        if (wr_en) begin
            case (addr)
                A_CSET: begin
                    if (wdata[B_BRK]) r_d.brk = 1'b1;
                    if (wdata[B_RTS]) r_d.rts = 1'b1;
                    r_d.rx_rst = wdata[B_RXRST];
                    r_d.tx_rst = wdata[B_TXRST];
                end
                A_CCLR: begin
                    if (wdata[B_BRK]) r_d.brk = 1'b0;
                    if (wdata[B_RTS]) r_d.rts = 1'b0;
                end
                A_CTRL: r_d.flow_en = wdata[B_FLOWEN];
                A_TRIG: r_d.lvl     = wdata[LVL_LSB +: LVL_W];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.brk     <= 1'b0;
            r_q.rts     <= 1'b0;
            r_q.flow_en <= 1'b0;
            r_q.lvl     <= LVL_W'(RST_LVL);
            r_q.rx_rst  <= 1'b0;
            r_q.tx_rst  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign brk     = r_q.brk;
    assign rts_cmd = r_q.rts;
    assign flow_en = r_q.flow_en;
    assign lvl     = r_q.lvl;
    assign rx_rst  = r_q.rx_rst;
    assign tx_rst  = r_q.tx_rst;
endmodule

// File: rtl/ucf_sync.sv
module ucf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] s_d, s_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb s_d = din;
        end else begin : g_chain
            always_comb s_d = {s_q[STAGES-2:0], din};
        end
    endgenerate

    // reset to the inactive (high) level of an active-low line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign dout = s_q[STAGES-1];
endmodule

// File: rtl/ucf_gate.sv
module ucf_gate #(
    parameter int unsigned LVL_W = 5,
    parameter int unsigned RXL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rts_cmd,
    input  logic             flow_en,
    input  logic [LVL_W-1:0] lvl,
    input  logic [RXL_W-1:0] rx_level,
    input  logic             cts_sync_n,
    input  logic             brk,
    input  logic             tx_ser_in,
    output logic             rts_n,
    output logic             tx_start_ok,
    output logic             txd
);
    typedef struct packed {
        logic rts_n;
    } gate_t;

    gate_t g_d, g_q;
    logic  full_w;

    always_comb begin
        full_w        = rx_level >= RXL_W'(lvl);
        g_d.rts_n     = !(rts_cmd && !(flow_en && full_w));
        tx_start_ok   = !(flow_en && cts_sync_n);
        txd           = brk ? 1'b0 : tx_ser_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q.rts_n <= 1'b1;
        else        g_q       <= g_d;
    end

    assign rts_n = g_q.rts_n;
endmodule

// File: rtl/uart_cmd_flowctl.sv
module uart_cmd_flowctl
    import ucf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned LVL_W       = 5,
    parameter int unsigned RXL_W       = LVL_W + 2,
    parameter int unsigned RST_LVL     = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [RXL_W-1:0]  rx_level,
    input  logic              cts_n,
    input  logic              tx_ser_in,
    output logic              rts_n,
    output logic              tx_start_ok,
    output logic              txd,
    output logic              rx_fifo_rst,
    output logic              tx_fifo_rst
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_CSET = ADDR_W'(OFS_CSET);
    localparam logic [ADDR_W-1:0] A_CCLR = ADDR_W'(OFS_CCLR);

    logic             brk_w, rts_cmd_w, flow_en_w, cts_s_w;
    logic [LVL_W-1:0] lvl_w;

    ucf_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .RST_LVL(RST_LVL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .brk(brk_w), .rts_cmd(rts_cmd_w), .flow_en(flow_en_w), .lvl(lvl_w),
        .rx_rst(rx_fifo_rst), .tx_rst(tx_fifo_rst)
    );

    ucf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cts_n), .dout(cts_s_w)
    );

    ucf_gate #(.LVL_W(LVL_W), .RXL_W(RXL_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .rts_cmd(rts_cmd_w), .flow_en(flow_en_w),
        .lvl(lvl_w), .rx_level(rx_level), .cts_sync_n(cts_s_w), .brk(brk_w),
        .tx_ser_in(tx_ser_in), .rts_n(rts_n), .tx_start_ok(tx_start_ok),
        .txd(txd)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata[B_FLOWEN] = flow_en_w;
            A_STAT: rdata[B_CTS]    = cts_s_w;
            A_TRIG: rdata[LVL_LSB +: LVL_W] = lvl_w;
            A_CSET, A_CCLR: begin
                rdata[B_BRK] = brk_w;
                rdata[B_RTS] = rts_cmd_w;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ucf_checker.sv
module ucf_checker
    import ucf_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LVL_W  = 5,
    parameter int unsigned RXL_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [RXL_W-1:0]  rx_level,
    input logic              rts_n,
    input logic              tx_start_ok,
    input logic              txd,
    input logic              rx_fifo_rst,
    input logic              brk,
    input logic              rts_cmd,
    input logic              flow_en,
    input logic              cts_s,
    input logic [LVL_W-1:0]  lvl
);
    localparam logic [ADDR_W-1:0] A_CSET = ADDR_W'(OFS_CSET);
    localparam logic [ADDR_W-1:0] A_CCLR = ADDR_W'(OFS_CCLR);

    p_set_brk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CSET && wdata[B_BRK]) |=> brk);

    p_clr_rts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CCLR && wdata[B_RTS]) |=> !rts_cmd);

    p_rst_bits_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CSET || addr == A_CCLR) |-> (rdata[B_TXRST:B_RXRST] == 2'b00));

    p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_rst |-> $past(wr_en && addr == A_CSET && wdata[B_RXRST]));

    p_rts_withdrawn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && rx_level >= RXL_W'(lvl)) |=> rts_n);

    p_start_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && cts_s) |-> !tx_start_ok);

    p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);
endmodule

bind uart_cmd_flowctl ucf_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .RXL_W(RXL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rx_level(rx_level), .rts_n(rts_n),
    .tx_start_ok(tx_start_ok), .txd(txd), .rx_fifo_rst(rx_fifo_rst),
    .brk(brk_w), .rts_cmd(rts_cmd_w), .flow_en(flow_en_w), .cts_s(cts_s_w),
    .lvl(lvl_w)
);

// File: tb/sim_uart_cmd_flowctl.sv
module sim_uart_cmd_flowctl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int RW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [RW-1:0] rx_level = '0;
    logic          cts_n = 1'b0;
    logic          tx_ser_in = 1'b1;
    logic          rts_n, tx_start_ok, txd, rx_fifo_rst, tx_fifo_rst;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_cmd_flowctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rx_level(rx_level), .cts_n(cts_n),
        .tx_ser_in(tx_ser_in), .rts_n(rts_n), .tx_start_ok(tx_start_ok),
        .txd(txd), .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog all-R: cycles %0d expected below 5000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // write: drive at a falling edge, return at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    // {use_set_address, data[7:0], expected_cmd_readback[7:0]}
    localparam logic [16:0] VEC [8] = '{
        {1'b1, 8'h08, 8'h08},
        {1'b1, 8'h20, 8'h28},
        {1'b0, 8'h08, 8'h20},
        {1'b1, 8'hC0, 8'h20},
        {1'b0, 8'hFF, 8'h00},
        {1'b1, 8'h3F, 8'h28},
        {1'b0, 8'h20, 8'h08},
        {1'b0, 8'h08, 8'h00}
    };

    initial begin
        logic [31:0] v;
        // ---------- reset state (R11)
        #(CLK_PERIOD*3);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        rd(8'h18, v);  check(v, 32'h0, "R11 cmd readback");
        rd(8'h00, v);  check(v, 32'h0, "R11 ctrl readback");
        rd(8'h14, v);  check(v, 32'h0010_0000, "R11 threshold");
        check({31'b0, rts_n}, 1, "R11 rts_n");
        check({31'b0, tx_start_ok}, 1, "R11 tx_start_ok");
        check({30'b0, rx_fifo_rst, tx_fifo_rst}, 0, "R11 strobes");
        check({31'b0, txd}, 1, "R11 txd passthrough");

        // ---------- table: set/clear semantics and strobes (R1 R2 R3 R4)
        for (int i = 0; i < 8; i++) begin
            logic       s;
            logic [7:0] d, e;
            {s, d, e} = VEC[i];
            wr(s ? 8'h18 : 8'h1C, {24'b0, d});
            check({30'b0, rx_fifo_rst, tx_fifo_rst},
                  {30'b0, s & d[6], s & d[7]}, "R4 strobe on write");
            rd(s ? 8'h1C : 8'h18, v);
            check(v, {24'b0, e}, s ? "R1 R3 set readback" : "R2 R3 clear readback");
            @(negedge clk);
            check({30'b0, rx_fifo_rst, tx_fifo_rst}, 0, "R4 strobe one cycle");
        end

        // ---------- control/trigger fields (R5)
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check(v, 32'h0080_0000, "R5 flow enable field");
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); check(v, 32'h001F_0000, "R5 threshold field");
        wr(8'h00, 32'h0);
        wr(8'h14, 32'd8 << 16);
        rd(8'h14, v); check(v, 32'h0008_0000, "R5 threshold 8");

        // ---------- RTS with flow control off (R6)
        rx_level = 7'd20;
        wr(8'h18, 32'h20);
        check({31'b0, rts_n}, 1, "R6 rts_n not yet updated");
        @(negedge clk);
        check({31'b0, rts_n}, 0, "R6 rts asserted, flow off, level high");

        // ---------- automatic withdrawal (R7 R6)
        wr(8'h00, 32'h0080_0000);
        @(negedge clk);
        check({31'b0, rts_n}, 1, "R7 withdrawn above threshold");
        rx_level = 7'd8;
        @(negedge clk);
        check({31'b0, rts_n}, 1, "R7 withdrawn at threshold");
        rx_level = 7'd7;
        @(negedge clk);
        check({31'b0, rts_n}, 0, "R6 asserted below threshold");
        wr(8'h1C, 32'h20);
        @(negedge clk);
        check({31'b0, rts_n}, 1, "R6 cleared command deasserts");

        // ---------- CTS gating (R8 R9), flow control still on
        tx_ser_in = 1'b0;
        cts_n = 1'b1;
        @(negedge clk);
        check({31'b0, tx_start_ok}, 1, "R8 first stage only");
        @(negedge clk);
        check({31'b0, tx_start_ok}, 0, "R9 new frame held");
        check({31'b0, txd}, 0, "R9 current frame continues low");
        tx_ser_in = 1'b1;
        #1 check({31'b0, txd}, 1, "R9 current frame continues high");
        rd(8'h04, v); check(v, 32'h0200_0000, "R8 status cts inactive");
        cts_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({31'b0, tx_start_ok}, 1, "R9 released");
        rd(8'h04, v); check(v, 32'h0, "R8 status cts active");
        cts_n = 1'b1;
        wr(8'h00, 32'h0);
        @(negedge clk);
        check({31'b0, tx_start_ok}, 1, "R9 flow off ignores cts");

        // ---------- break (R10)
        tx_ser_in = 1'b1;
        wr(8'h18, 32'h08);
        check({31'b0, txd}, 0, "R10 break forces low");
        wr(8'h1C, 32'h08);
        check({31'b0, txd}, 1, "R10 break released");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule